// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor front end and its first-level instruction and data cache controllers. It keeps a record of every memory request that is in flight, keyed by cache-line address. A request is a load, an instruction fetch, a store, or one of the two halves of an atomic read-modify-write pair. The block refuses a new request when the total number in flight has reached its limit, when the request's bytes run past the end of a cache line, or when its line already has a request in flight. An accepted request goes to the cache side one cycle later, with a kind code, the latency of the cache that will serve it and a unique id.

Loads and fetches are held in a read table, and stores and both atomic halves in a write table. When the cache reports that a line is complete, the block removes the matching entry. It then reports the id and the latency in cycles, and tells the cache which line to mark most recently used. For atomics, finishing the read half places a reservation lock on the line. Finishing the write half succeeds only if that lock is still held on the same line, and success releases the lock. A periodic age check raises a sticky flag if any entry stays in flight for too long.

Top module: `req_tracker`

## Requirements
- R1: After reset, outstanding is 0, fwdValid, doneValid, cplMiss, mruValid and deadlock are 0, and reqReady is 1 for a legal request.
- R2: A request's line is reqAddr[15:4] and its offset is reqAddr[3:0]. It is refused (reqReady=0) when offset+reqLen exceeds 16 bytes, and otherwise it is accepted when nothing else blocks it.
- R3: While outstanding equals MAX_OUT (4), every request is refused.
- R4: A request whose line is already in either table is refused, whatever its offset or kind.
- R5: Kind codes are 0 load and 1 fetch, which go to the read table, and 2 store, 3 atomic-read and 4 atomic-write, which go to the write table. Codes 5 to 7 are refused.
- R6: In the cycle after an acceptance, fwdValid=1 with fwdLine equal to the request line. fwdKind is 0 for a load, 1 for a fetch, 2 for a store and 3 for either atomic half. fwdLatency is INST_LAT (2) for fetches and DATA_LAT (3) otherwise.
- R7: reqId shows the id the next acceptance takes. Ids start at 0 after reset and rise by one per acceptance. fwdId and doneId carry the id.
- R8: outstanding rises by one on an acceptance and falls by one on a completion that hits, and is unchanged when both happen in the same cycle.
- R9: cplWrite=1 looks up cplLine in the write table and cplWrite=0 in the read table. On a hit, doneValid pulses in the next cycle, and doneLatency is the number of clock edges from the accepting edge to the completing edge. On a miss, cplMiss pulses and no entry is removed.
- R10: mruValid pulses with doneValid, with mruLine equal to the completed line and mruInst=1 only when the completed request was a fetch.
- R11: Completing an atomic-read sets the lock on its line. Completing an atomic-write reports doneAtomicWr=1, with doneAtomicOk=1 and the lock released if the lock is held on that line, and doneAtomicOk=0 otherwise.
- R12: The age check runs every DL_THRESH cycles, starting from the first acceptance made while it was idle, for as long as requests remain. deadlock becomes 1, and stays 1 until reset, when a check finds an entry whose age is at least DL_THRESH. With nothing in flight, the check stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New request present |
| reqKind | input | 3 | Request kind code |
| reqAddr | input | ADDR_W | Request byte address |
| reqLen | input | LEN_W | Request length in bytes |
| reqReady | output | 1 | Request would be accepted this cycle |
| reqId | output | ID_W | Id the next acceptance takes |
| fwdValid | output | 1 | Forwarded request valid |
| fwdLine | output | LINE_W | Forwarded line address |
| fwdKind | output | 2 | Forwarded cache request kind |
| fwdLatency | output | LAT_W | Latency of the serving cache |
| fwdId | output | ID_W | Forwarded request id |
| cplValid | input | 1 | Completion from the cache |
| cplWrite | input | 1 | Completion targets the write table |
| cplLine | input | LINE_W | Completed line address |
| doneValid | output | 1 | Request retired |
| doneId | output | ID_W | Id of the retired request |
| doneLatency | output | TIME_W | Cycles from acceptance to completion |
| doneAtomicWr | output | 1 | Retired request was an atomic-write |
| doneAtomicOk | output | 1 | Atomic-write succeeded |
| cplMiss | output | 1 | Completion matched no entry |
| mruValid | output | 1 | Mark a line most recently used |
| mruInst | output | 1 | Target the instruction cache |
| mruLine | output | LINE_W | Line to mark |
| outstanding | output | CNT_W | Requests in flight |
| deadlock | output | 1 | Sticky stuck-entry flag |

## Verification
The assertions assume that reqKind, reqAddr and reqLen are stable and known whenever reqValid is high, and that a completion names a line the caller believes to be outstanding. The miss path is the one exception, and it is driven on purpose. The stimulus drives every input on the falling edge and holds it for one full cycle. It raises at most one acceptance and one completion per cycle. It keeps each entry's life well below the age limit, except in the final stuck-entry scenario, so the flag rises only where that scenario expects it.

// File: rtl/req_tracker_pkg.sv
`timescale 1ns/1ps
package req_tracker_pkg;

  typedef enum logic [2:0] {
    KIND_LOAD    = 3'd0,
    KIND_FETCH   = 3'd1,
    KIND_STORE   = 3'd2,
    KIND_ATOM_RD = 3'd3,
    KIND_ATOM_WR = 3'd4
  } reqKind_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic insRd;
    logic insWr;
    logic remRd;
    logic remWr;
    logic doneLoad;
    logic missLoad;
    logic lockSet;
    logic lockClr;
    logic dlSet;
  } ctlStrobe_t;

endpackage

// File: rtl/req_tracker_table.sv
`timescale 1ns/1ps
module req_tracker_table
  import req_tracker_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int LINE_W    = 12,
  parameter int ID_W      = 8,
  parameter int TIME_W    = 16,
  parameter int DL_THRESH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insEn,
  input  logic [LINE_W-1:0] insLine,
  input  reqKind_e          insKind,
  input  logic [ID_W-1:0]   insId,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              remEn,
  input  logic [LINE_W-1:0] remLine,
  input  logic [LINE_W-1:0] lookLine,
  output logic              lookHit,
  output logic              remHit,
  output reqKind_e          remKind,
  output logic [ID_W-1:0]   remId,
  output logic [TIME_W-1:0] remTime,
  output logic              staleAny
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [TIME_W-1:0] THRESH_T = TIME_W'(DL_THRESH);

  logic              validQ [ENTRIES];
  logic [LINE_W-1:0] lineQ  [ENTRIES];
  reqKind_e          kindQ  [ENTRIES];
  logic [ID_W-1:0]   idQ    [ENTRIES];
  logic [TIME_W-1:0] stampQ [ENTRIES];

  logic [ENTRIES-1:0] lookVec, remVec, staleVec;
  logic [IDX_W-1:0]   freeIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign lookVec[g]  = validQ[g] && (lineQ[g] == lookLine);
    assign remVec[g]   = validQ[g] && (lineQ[g] == remLine);
    assign staleVec[g] = validQ[g] && ((timeNow - stampQ[g]) >= THRESH_T);
  end

  assign lookHit  = |lookVec;
  assign remHit   = |remVec;
  assign staleAny = |staleVec;

  // lowest free slot: the downward scan leaves the smallest index last
  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) freeIdx = IDX_W'(i);
    end
  end

  // at most one entry matches a line, so an OR mux is enough
  always_comb begin
    remKind = KIND_LOAD;
    remId   = '0;
    remTime = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (remVec[i]) begin
        remKind = reqKind_e'(remKind | kindQ[i]);
        remId   = remId | idQ[i];
        remTime = remTime | stampQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        lineQ[i]  <= '0;
        kindQ[i]  <= KIND_LOAD;
        idQ[i]    <= '0;
        stampQ[i] <= '0;
      end else begin
        if (remEn && remVec[i]) validQ[i] <= 1'b0;
        if (insEn && (freeIdx == IDX_W'(i))) begin
          validQ[i] <= 1'b1;
          lineQ[i]  <= insLine;
          kindQ[i]  <= insKind;
          idQ[i]    <= insId;
          stampQ[i] <= timeNow;
        end
      end
    end
  end

endmodule

// File: rtl/req_tracker_ctl.sv
`timescale 1ns/1ps
module req_tracker_ctl
  import req_tracker_pkg::*;
#(
  parameter int MAX_OUT     = 4,
  parameter int OFF_W       = 4,
  parameter int LEN_W       = 5,
  parameter int DL_THRESH   = 64,
  parameter int CNT_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  reqKind_e          reqKind,
  input  logic [2:0]        reqKindRaw,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqReady,
  input  logic              lookHitRd,
  input  logic              lookHitWr,
  input  logic              cplValid,
  input  logic              cplWrite,
  input  logic              remHitRd,
  input  logic              remHitWr,
  input  reqKind_e          remKindWr,
  input  logic              lockMatch,
  input  logic              staleAny,
  input  logic [CNT_W-1:0]  outstanding,
  output ctlStrobe_t        st
);

  localparam int BLOCK_BYTES = 1 << OFF_W;
  localparam int SUM_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 2;
  localparam int WD_W  = $clog2(DL_THRESH + 1);
  localparam logic [WD_W-1:0] WD_RELOAD = WD_W'(DL_THRESH - 1);

  logic [SUM_W-1:0] span;
  logic             legal, kindOk, room, accept, isWrite;
  logic             cplHit;
  logic [CNT_W-1:0] countNext;
  logic             armedQ, fire;
  logic [WD_W-1:0]  wdTimerQ;

  assign span    = SUM_W'(reqOffset) + SUM_W'(reqLen);
  assign legal   = span <= SUM_W'(BLOCK_BYTES);
  assign kindOk  = reqKindRaw <= 3'd4;
  assign room    = outstanding < CNT_W'(MAX_OUT);
  assign reqReady = legal && kindOk && room && !lookHitRd && !lookHitWr;
  assign accept  = reqValid && reqReady;
  assign isWrite = (reqKind == KIND_STORE) || (reqKind == KIND_ATOM_RD) ||
                   (reqKind == KIND_ATOM_WR);

  assign cplHit = cplWrite ? remHitWr : remHitRd;

  always_comb begin
    st          = '0;
    st.insRd    = accept && !isWrite;
    st.insWr    = accept && isWrite;
    st.remRd    = cplValid && !cplWrite && remHitRd;
    st.remWr    = cplValid && cplWrite && remHitWr;
    st.doneLoad = cplValid && cplHit;
    st.missLoad = cplValid && !cplHit;
    st.lockSet  = st.remWr && (remKindWr == KIND_ATOM_RD);
    st.lockClr  = st.remWr && (remKindWr == KIND_ATOM_WR) && lockMatch;
    st.dlSet    = fire && staleAny;
  end

  assign countNext = outstanding + CNT_W'(accept) - CNT_W'(st.remRd | st.remWr);
  assign fire      = armedQ && (wdTimerQ == '0);

  // periodic age check: armed by an acceptance, reloads while work remains
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ   <= 1'b0;
      wdTimerQ <= '0;
    end else if (!armedQ) begin
      if (accept) begin
        armedQ   <= 1'b1;
        wdTimerQ <= WD_RELOAD;
      end
    end else if (fire) begin
      if (countNext != '0) wdTimerQ <= WD_RELOAD;
      else                 armedQ   <= 1'b0;
    end else begin
      wdTimerQ <= wdTimerQ - 1'b1;
    end
  end

endmodule

// File: rtl/req_tracker_dp.sv
`timescale 1ns/1ps
module req_tracker_dp
  import req_tracker_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int LINE_W    = 12,
  parameter int ID_W      = 8,
  parameter int TIME_W    = 16,
  parameter int LAT_W     = 8,
  parameter int CNT_W     = 3,
  parameter int DL_THRESH = 64,
  parameter int INST_LAT  = 2,
  parameter int DATA_LAT  = 3,
  parameter int OWNER_ID  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic [LINE_W-1:0] reqLine,
  input  reqKind_e          reqKind,
  input  logic              cplWrite,
  input  logic [LINE_W-1:0] cplLine,
  output logic              lookHitRd,
  output logic              lookHitWr,
  output logic              remHitRd,
  output logic              remHitWr,
  output reqKind_e          remKindWr,
  output logic              lockMatch,
  output logic              staleAny,
  output logic [ID_W-1:0]   reqId,
  output logic              fwdValid,
  output logic [LINE_W-1:0] fwdLine,
  output logic [1:0]        fwdKind,
  output logic [LAT_W-1:0]  fwdLatency,
  output logic [ID_W-1:0]   fwdId,
  output logic              doneValid,
  output logic [ID_W-1:0]   doneId,
  output logic [TIME_W-1:0] doneLatency,
  output logic              doneAtomicWr,
  output logic              doneAtomicOk,
  output logic              cplMiss,
  output logic              mruValid,
  output logic              mruInst,
  output logic [LINE_W-1:0] mruLine,
  output logic [CNT_W-1:0]  outstanding,
  output logic              deadlock
);

  localparam int OWN_W = 8;

  logic [TIME_W-1:0] timeNowQ;
  logic [ID_W-1:0]   nextIdQ;
  logic              lockValidQ;
  logic [LINE_W-1:0] lockLineQ;
  logic [OWN_W-1:0]  lockOwnerQ;

  reqKind_e          remKindRd;
  logic [ID_W-1:0]   remIdRd, remIdWr, selId;
  logic [TIME_W-1:0] remTimeRd, remTimeWr, selTime;
  logic              staleRd, staleWr;
  reqKind_e          selKind;

  req_tracker_table #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W),
    .TIME_W(TIME_W), .DL_THRESH(DL_THRESH)
  ) rdTable_i (
    .clk(clk), .rstN(rstN),
    .insEn(st.insRd), .insLine(reqLine), .insKind(reqKind), .insId(nextIdQ),
    .timeNow(timeNowQ), .remEn(st.remRd), .remLine(cplLine), .lookLine(reqLine),
    .lookHit(lookHitRd), .remHit(remHitRd), .remKind(remKindRd),
    .remId(remIdRd), .remTime(remTimeRd), .staleAny(staleRd)
  );

  req_tracker_table #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W),
    .TIME_W(TIME_W), .DL_THRESH(DL_THRESH)
  ) wrTable_i (
    .clk(clk), .rstN(rstN),
    .insEn(st.insWr), .insLine(reqLine), .insKind(reqKind), .insId(nextIdQ),
    .timeNow(timeNowQ), .remEn(st.remWr), .remLine(cplLine), .lookLine(reqLine),
    .lookHit(lookHitWr), .remHit(remHitWr), .remKind(remKindWr),
    .remId(remIdWr), .remTime(remTimeWr), .staleAny(staleWr)
  );

  assign staleAny  = staleRd | staleWr;
  assign selKind   = cplWrite ? remKindWr : remKindRd;
  assign selId     = cplWrite ? remIdWr : remIdRd;
  assign selTime   = cplWrite ? remTimeWr : remTimeRd;
  assign lockMatch = lockValidQ && (lockLineQ == cplLine) &&
                     (lockOwnerQ == OWN_W'(OWNER_ID));
  assign reqId     = nextIdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeNowQ    <= '0;
      nextIdQ     <= '0;
      outstanding <= '0;
      lockValidQ  <= 1'b0;
      lockLineQ   <= '0;
      lockOwnerQ  <= '0;
      deadlock    <= 1'b0;
      fwdValid    <= 1'b0;
      fwdLine     <= '0;
      fwdKind     <= '0;
      fwdLatency  <= '0;
      fwdId       <= '0;
      doneValid   <= 1'b0;
      doneId      <= '0;
      doneLatency <= '0;
      doneAtomicWr <= 1'b0;
      doneAtomicOk <= 1'b0;
      cplMiss     <= 1'b0;
      mruValid    <= 1'b0;
      mruInst     <= 1'b0;
      mruLine     <= '0;
    end else begin
      timeNowQ    <= timeNowQ + 1'b1;
      outstanding <= outstanding + CNT_W'(st.insRd | st.insWr)
                                 - CNT_W'(st.remRd | st.remWr);
      if (st.dlSet) deadlock <= 1'b1;

      if (st.lockSet) begin
        lockValidQ <= 1'b1;
        lockLineQ  <= cplLine;
        lockOwnerQ <= OWN_W'(OWNER_ID);
      end else if (st.lockClr) begin
        lockValidQ <= 1'b0;
      end

      fwdValid <= st.insRd | st.insWr;
      if (st.insRd | st.insWr) begin
        nextIdQ    <= nextIdQ + 1'b1;
        fwdLine    <= reqLine;
        fwdId      <= nextIdQ;
        fwdLatency <= (reqKind == KIND_FETCH) ? LAT_W'(INST_LAT) : LAT_W'(DATA_LAT);
        case (reqKind)
          KIND_LOAD:  fwdKind <= 2'd0;
          KIND_FETCH: fwdKind <= 2'd1;
          KIND_STORE: fwdKind <= 2'd2;
          default:    fwdKind <= 2'd3;
        endcase
      end

      doneValid <= st.doneLoad;
      mruValid  <= st.doneLoad;
      cplMiss   <= st.missLoad;
      if (st.doneLoad) begin
        doneId       <= selId;
        doneLatency  <= timeNowQ - selTime;
        doneAtomicWr <= selKind == KIND_ATOM_WR;
        doneAtomicOk <= st.lockClr;
        mruInst      <= selKind == KIND_FETCH;
        mruLine      <= cplLine;
      end else begin
        doneAtomicWr <= 1'b0;
        doneAtomicOk <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/req_tracker.sv
`timescale 1ns/1ps
module req_tracker
  import req_tracker_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 4,
  parameter int LEN_W     = 5,
  parameter int ID_W      = 8,
  parameter int TIME_W    = 16,
  parameter int LAT_W     = 8,
  parameter int MAX_OUT   = 4,
  parameter int ENTRIES   = 4,
  parameter int DL_THRESH = 64,
  parameter int INST_LAT  = 2,
  parameter int DATA_LAT  = 3,
  parameter int OWNER_ID  = 5,
  localparam int LINE_W   = ADDR_W - OFF_W,
  localparam int CNT_W    = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqReady,
  output logic [ID_W-1:0]   reqId,
  output logic              fwdValid,
  output logic [LINE_W-1:0] fwdLine,
  output logic [1:0]        fwdKind,
  output logic [LAT_W-1:0]  fwdLatency,
  output logic [ID_W-1:0]   fwdId,
  input  logic              cplValid,
  input  logic              cplWrite,
  input  logic [LINE_W-1:0] cplLine,
  output logic              doneValid,
  output logic [ID_W-1:0]   doneId,
  output logic [TIME_W-1:0] doneLatency,
  output logic              doneAtomicWr,
  output logic              doneAtomicOk,
  output logic              cplMiss,
  output logic              mruValid,
  output logic              mruInst,
  output logic [LINE_W-1:0] mruLine,
  output logic [CNT_W-1:0]  outstanding,
  output logic              deadlock
);

  ctlStrobe_t  st;
  reqKind_e    kindE, remKindWr;
  logic        lookHitRd, lookHitWr, remHitRd, remHitWr, lockMatch, staleAny;

  assign kindE = reqKind_e'(reqKind);

  req_tracker_ctl #(
    .MAX_OUT(MAX_OUT), .OFF_W(OFF_W), .LEN_W(LEN_W),
    .DL_THRESH(DL_THRESH), .CNT_W(CNT_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(kindE),
    .reqKindRaw(reqKind), .reqOffset(reqAddr[OFF_W-1:0]), .reqLen(reqLen),
    .reqReady(reqReady), .lookHitRd(lookHitRd), .lookHitWr(lookHitWr),
    .cplValid(cplValid), .cplWrite(cplWrite), .remHitRd(remHitRd),
    .remHitWr(remHitWr), .remKindWr(remKindWr), .lockMatch(lockMatch),
    .staleAny(staleAny), .outstanding(outstanding), .st(st)
  );

  req_tracker_dp #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W), .TIME_W(TIME_W),
    .LAT_W(LAT_W), .CNT_W(CNT_W), .DL_THRESH(DL_THRESH),
    .INST_LAT(INST_LAT), .DATA_LAT(DATA_LAT), .OWNER_ID(OWNER_ID)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .reqLine(reqAddr[ADDR_W-1:OFF_W]),
    .reqKind(kindE), .cplWrite(cplWrite), .cplLine(cplLine),
    .lookHitRd(lookHitRd), .lookHitWr(lookHitWr), .remHitRd(remHitRd),
    .remHitWr(remHitWr), .remKindWr(remKindWr), .lockMatch(lockMatch),
    .staleAny(staleAny), .reqId(reqId), .fwdValid(fwdValid),
    .fwdLine(fwdLine), .fwdKind(fwdKind), .fwdLatency(fwdLatency),
    .fwdId(fwdId), .doneValid(doneValid), .doneId(doneId),
    .doneLatency(doneLatency), .doneAtomicWr(doneAtomicWr),
    .doneAtomicOk(doneAtomicOk), .cplMiss(cplMiss), .mruValid(mruValid),
    .mruInst(mruInst), .mruLine(mruLine), .outstanding(outstanding),
    .deadlock(deadlock)
  );

endmodule

// File: rtl/req_tracker_chk.sv
`timescale 1ns/1ps
module req_tracker_chk #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int LEN_W   = 5,
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [LEN_W-1:0]  reqLen,
  input logic              fwdValid,
  input logic              cplValid,
  input logic              doneValid,
  input logic              doneAtomicWr,
  input logic              doneAtomicOk,
  input logic [CNT_W-1:0]  outstanding,
  input logic              deadlock
);

  localparam int W = LEN_W + OFF_W + 2;
  logic overRun;
  assign overRun = (W'(reqAddr[OFF_W-1:0]) + W'(reqLen)) > W'(1 << OFF_W);

  assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= CNT_W'(MAX_OUT));

  assert_illegal_refused_R2: assert property (@(posedge clk) disable iff (!rstN)
    overRun |-> !reqReady);

  assert_fwd_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> fwdValid);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !cplValid) |=> (outstanding == $past(outstanding) + 1'b1));

  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(cplValid));

  assert_ok_only_on_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneAtomicOk |-> (doneValid && doneAtomicWr));

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    deadlock |=> deadlock);

endmodule

bind req_tracker req_tracker_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W),
  .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqLen(reqLen), .fwdValid(fwdValid),
  .cplValid(cplValid), .doneValid(doneValid), .doneAtomicWr(doneAtomicWr),
  .doneAtomicOk(doneAtomicOk), .outstanding(outstanding), .deadlock(deadlock)
);

// File: tb/req_tracker_tb_top.sv
`timescale 1ns/1ps
module req_tracker_tb_top;

  localparam int THRESH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'd0;
  logic [4:0]  reqLen = 5'd1;
  logic        reqReady;
  logic [7:0]  reqId;
  logic        fwdValid;
  logic [11:0] fwdLine;
  logic [1:0]  fwdKind;
  logic [7:0]  fwdLatency;
  logic [7:0]  fwdId;
  logic        cplValid = 1'b0;
  logic        cplWrite = 1'b0;
  logic [11:0] cplLine = 12'd0;
  logic        doneValid;
  logic [7:0]  doneId;
  logic [15:0] doneLatency;
  logic        doneAtomicWr, doneAtomicOk, cplMiss, mruValid, mruInst;
  logic [11:0] mruLine;
  logic [2:0]  outstanding;
  logic        deadlock;

  int errors = 0;
  int checks = 0;
  int nextId = 0;

  always #10 clk = ~clk;

  req_tracker #(.DL_THRESH(THRESH)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqReady(reqReady), .reqId(reqId),
    .fwdValid(fwdValid), .fwdLine(fwdLine), .fwdKind(fwdKind),
    .fwdLatency(fwdLatency), .fwdId(fwdId), .cplValid(cplValid),
    .cplWrite(cplWrite), .cplLine(cplLine), .doneValid(doneValid),
    .doneId(doneId), .doneLatency(doneLatency), .doneAtomicWr(doneAtomicWr),
    .doneAtomicOk(doneAtomicOk), .cplMiss(cplMiss), .mruValid(mruValid),
    .mruInst(mruInst), .mruLine(mruLine), .outstanding(outstanding),
    .deadlock(deadlock)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic issue(input string tag, input int kind, input int line, input int off,
                       input int len, input bit expReady, input int expCnt,
                       output time ta, output int idOut);
    @(negedge clk);
    reqValid = 1'b1;
    reqKind  = 3'(kind);
    reqAddr  = 16'((line << 4) | off);
    reqLen   = 5'(len);
    ta = $time;
    #1;
    chk(tag, "reqReady", reqReady, expReady);
    if (expReady) chk("R7", "reqId", reqId, nextId);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(tag, "fwdValid", fwdValid, expReady);
    idOut = -1;
    if (expReady) begin
      chk("R6", "fwdLine", fwdLine, line);
      chk("R6", "fwdKind", fwdKind, (kind >= 3) ? 3 : kind);
      chk("R6", "fwdLatency", fwdLatency, (kind == 1) ? 2 : 3);
      chk("R7", "fwdId", fwdId, nextId);
      idOut = nextId;
      nextId++;
    end
    chk("R8", "outstanding", outstanding, expCnt);
  endtask

  task automatic complete(input string tag, input bit wr, input int line, input bit expHit,
                          input int expId, input time ta, input int kind,
                          input bit expOk, input int expCnt);
    time tc;
    @(negedge clk);
    cplValid = 1'b1;
    cplWrite = wr;
    cplLine  = 12'(line);
    tc = $time;
    @(posedge clk);
    @(negedge clk);
    cplValid = 1'b0;
    chk(tag, "doneValid", doneValid, expHit);
    chk("R9", "cplMiss", cplMiss, !expHit);
    chk("R10", "mruValid", mruValid, expHit);
    if (expHit) begin
      chk("R9", "doneId", doneId, expId);
      chk("R9", "doneLatency", doneLatency, (tc - ta) / 20);
      chk("R10", "mruLine", mruLine, line);
      chk("R10", "mruInst", mruInst, kind == 1);
      chk("R11", "doneAtomicWr", doneAtomicWr, kind == 4);
      chk("R11", "doneAtomicOk", doneAtomicOk, expOk);
    end
    chk("R8", "outstanding", outstanding, expCnt);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    time t0, t1, t2, t3, tx;
    int  i0, i1, i2, i3, ix, iy;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: idle state after reset
    chk("R1", "outstanding", outstanding, 0);
    chk("R1", "fwdValid", fwdValid, 0);
    chk("R1", "doneValid", doneValid, 0);
    chk("R1", "cplMiss", cplMiss, 0);
    chk("R1", "mruValid", mruValid, 0);
    chk("R1", "deadlock", deadlock, 0);
    chk("R1", "reqReady", reqReady, 1);

    // R2: every offset and length pair against the 16-byte line
    for (int off = 0; off < 16; off++) begin
      for (int len = 0; len < 18; len++) begin
        reqAddr = 16'((7 << 4) | off);
        reqLen  = 5'(len);
        #1;
        chk("R2", "reqReady sweep", reqReady, (off + len) <= 16);
      end
    end
    // R5: unused kind codes are refused
    for (int k = 5; k < 8; k++) begin
      reqKind = 3'(k);
      reqAddr = 16'h0070;
      reqLen  = 5'd1;
      #1;
      chk("R5", "reqReady bad kind", reqReady, 0);
    end

    // fill to capacity with one of each table kind
    issue("R5", 0, 1, 3, 4, 1, 1, t0, i0);
    issue("R5", 1, 2, 0, 16, 1, 2, t1, i1);
    issue("R5", 2, 3, 8, 8, 1, 3, t2, i2);
    issue("R5", 3, 4, 0, 8, 1, 4, t3, i3);
    issue("R3", 0, 9, 0, 4, 0, 4, tx, ix);

    complete("R9", 0, 2, 1, i1, t1, 1, 0, 3);
    // R4: same line at another offset, across tables
    issue("R4", 2, 1, 8, 4, 0, 3, tx, ix);
    issue("R4", 0, 3, 0, 2, 0, 3, tx, ix);
    issue("R4", 4, 4, 4, 4, 0, 3, tx, ix);

    complete("R11", 1, 4, 1, i3, t3, 3, 0, 2);
    // R5/R9: a store line is not found by a read completion
    complete("R9", 0, 3, 0, 0, 0, 0, 0, 2);
    complete("R9", 0, 1, 1, i0, t0, 0, 0, 1);
    complete("R9", 1, 3, 1, i2, t2, 2, 0, 0);

    // R11: atomic write under the lock, then again without it
    issue("R11", 4, 4, 0, 4, 1, 1, t0, i0);
    complete("R11", 1, 4, 1, i0, t0, 4, 1, 0);
    issue("R11", 4, 4, 0, 4, 1, 1, t0, i0);
    complete("R11", 1, 4, 1, i0, t0, 4, 0, 0);
    issue("R11", 3, 6, 0, 4, 1, 1, t0, i0);
    complete("R11", 1, 6, 1, i0, t0, 3, 0, 0);
    issue("R11", 4, 7, 0, 4, 1, 1, t0, i0);
    repeat (2) @(posedge clk);
    complete("R11", 1, 7, 1, i0, t0, 4, 0, 0);

    // R8: acceptance and retirement in the same cycle
    issue("R8", 0, 10, 0, 4, 1, 1, t0, i0);
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd2; reqAddr = 16'((11 << 4)); reqLen = 5'd4;
    cplValid = 1'b1; cplWrite = 1'b0; cplLine = 12'd10;
    t1 = $time;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; cplValid = 1'b0;
    chk("R8", "outstanding same cycle", outstanding, 1);
    chk("R8", "fwdValid same cycle", fwdValid, 1);
    chk("R8", "doneValid same cycle", doneValid, 1);
    chk("R9", "doneLatency same cycle", doneLatency, (t1 - t0) / 20);
    i1 = nextId; nextId++;
    complete("R9", 1, 11, 1, i1, t1, 2, 0, 0);

    // R12: nothing in flight, the flag stays low
    repeat (3 * THRESH) @(posedge clk);
    @(negedge clk);
    chk("R12", "deadlock idle", deadlock, 0);

    // R12: a stuck entry is flagged on the first check
    issue("R12", 0, 12, 0, 4, 1, 1, t0, i0);
    repeat (THRESH - 1) @(posedge clk);
    @(negedge clk);
    chk("R12", "deadlock before limit", deadlock, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R12", "deadlock at limit", deadlock, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R12", "deadlock sticky", deadlock, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule